// File: doc/BRIEF.md
# Carry-Save Running Accumulator

This block keeps a signed running total of a stream of narrow two's-complement samples. On every clock edge where the enable is high, the sample on `a` is sign-extended to the width of the total and added to it. The total wraps modulo 2^ACC_W, and the sum is taken at the output `x`.

The total is never held as a plain binary number. It is held as a redundant pair: a sum vector and a carry vector whose arithmetic sum is the total. Each cycle a 3:2 compressor merges the extended sample with the pair, so the feedback path through the state registers has one full-adder level per bit and no carry chain. A carry-propagate adder outside the loop resolves the pair into `x`. With the default setting a register follows that adder, so `x` shows the total one cycle after the state is updated. The other setting drives `x` straight from the adder.

An active-low reset clears both vectors and the output register at once, without waiting for a clock edge.

Top module: `csa_accum`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes high, both state vectors are zero and `x` reads 0. The clear takes effect without a clock edge.
- R2: A sample with bit 31 set counts as negative. It is sign-extended before it is added, so a run of negative samples lowers the total by their magnitudes.
- R3: After each enabled edge, sum vector plus carry vector equals the previous total plus the sign-extended sample, modulo 2^64. A total that goes below zero shows as the 64-bit two's-complement value.
- R4: On an edge where `en` is low, both state vectors keep their values and `x` keeps showing the same total.
- R5: With the registered output mode (the default), `x` after edge k equals the resolved total from before edge k. This is a latency of one cycle after the state update. In combinational mode there is no added latency.
- R6: Alternating extreme samples (0x7FFFFFFF and 0x80000000), and samples that change every cycle, accumulate exactly as the plain 64-bit sum does.
- R7: Pulling `rst_n` low in the middle of a run clears the total. Accumulation then restarts from 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | When high, the sample is added on this edge |
| a | input | 32 | Signed input sample |
| x | output | 64 | Resolved running total, modulo 2^64 |

## Verification
The hardest condition to reach from the ports is a carry vector that stays busy over the whole upper half of the word. That happens when sign extension adds long strings of ones every cycle and borrows ripple through the redundant pair for many edges in a row. The stimulus produces it in two ways: hundreds of back-to-back most-negative samples, and alternating extreme values that flip the sign of the sample every cycle. In both cases `x` is compared against a plain 64-bit sum on every cycle. A reset in the middle of a run then checks that the busy carry vector is really cleared.

// File: rtl/csa_accum_pkg.sv
package csa_accum_pkg;

    // Selects how the resolved total reaches the output port
    typedef enum logic {
        OUT_COMB       = 1'b0,
        OUT_REGISTERED = 1'b1
    } out_mode_e;

endpackage

// File: rtl/csa_compress.sv
// One full-adder level per bit: three operands in, a sum and a shifted carry out.
module csa_compress #(
    parameter int W = 64
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] op_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = op_x[i] ^ op_y[i] ^ op_z[i];
        assign maj[i]   = (op_x[i] & op_y[i]) | (op_x[i] & op_z[i]) | (op_y[i] & op_z[i]);
    end

    // carry has weight 2: move up one place, zero enters at bit 0, top carry dropped
    assign carry_o = {maj[W-2:0], 1'b0};

endmodule

// File: rtl/csa_state.sv
// The redundant sum/carry pair, cleared asynchronously and held when en is low.
module csa_state #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] sum_d,
    input  logic [W-1:0] carry_d,
    output logic [W-1:0] sum_q,
    output logic [W-1:0] carry_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= '0;
        end else if (en) begin
            sum_q   <= sum_d;
            carry_q <= carry_d;
        end
    end

endmodule

// File: rtl/csa_resolve.sv
// Carry-propagate adder outside the loop, with an optional output register.
module csa_resolve
    import csa_accum_pkg::*;
#(
    parameter int        W    = 64,
    parameter out_mode_e MODE = OUT_REGISTERED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] total_o
);

    logic [W-1:0] total_c;

    assign total_c = sum_i + carry_i;

    if (MODE == OUT_REGISTERED) begin : g_reg
        logic [W-1:0] total_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) total_q <= '0;
            else        total_q <= total_c;
        end
        assign total_o = total_q;
    end else begin : g_comb
        assign total_o = total_c;
    end

endmodule

// File: rtl/csa_accum.sv
module csa_accum
    import csa_accum_pkg::*;
#(
    parameter int        IN_W     = 32,
    parameter int        ACC_W    = 64,
    parameter out_mode_e OUT_MODE = OUT_REGISTERED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IN_W-1:0]  a,
    output logic [ACC_W-1:0] x
);

    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] a_ext;
    logic [ACC_W-1:0] sum_d;
    logic [ACC_W-1:0] carry_d;
    logic [ACC_W-1:0] sum_q;
    logic [ACC_W-1:0] carry_q;

    // sign extension of the incoming sample
    assign a_ext = {{EXT_W{a[IN_W-1]}}, a};

    csa_compress #(.W(ACC_W)) u_compress (
        .op_x    (a_ext),
        .op_y    (sum_q),
        .op_z    (carry_q),
        .sum_o   (sum_d),
        .carry_o (carry_d)
    );

    csa_state #(.W(ACC_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .sum_d   (sum_d),
        .carry_d (carry_d),
        .sum_q   (sum_q),
        .carry_q (carry_q)
    );

    csa_resolve #(.W(ACC_W), .MODE(OUT_MODE)) u_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .sum_i   (sum_q),
        .carry_i (carry_q),
        .total_o (x)
    );

endmodule

// File: rtl/csa_accum_chk.sv
module csa_accum_chk #(
    parameter int ACC_W   = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [ACC_W-1:0] a_ext,
    input logic [ACC_W-1:0] sum_q,
    input logic [ACC_W-1:0] carry_q,
    input logic [ACC_W-1:0] x
);

    logic [ACC_W-1:0] total;
    assign total = sum_q + carry_q;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_q == '0 && carry_q == '0 && x == '0));

    assert_total_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> total == ACC_W'($past(total) + $past(a_ext)));

    assert_hold_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sum_q) && $stable(carry_q)));

    if (REG_OUT) begin : g_reg
        assert_output_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> x == $past(total));
    end else begin : g_comb
        assert_output_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> x == total);
    end

endmodule

bind csa_accum csa_accum_chk #(
    .ACC_W   (ACC_W),
    .REG_OUT (OUT_MODE == csa_accum_pkg::OUT_REGISTERED)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .a_ext   (a_ext),
    .sum_q   (sum_q),
    .carry_q (carry_q),
    .x       (x)
);

// File: tb/test_csa_accum.sv
module test_csa_accum;

    localparam int LAT = 1;   // default registered output mode

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        en    = 1'b0;
    logic [31:0] a     = '0;
    logic [63:0] x;

    always #5 clk = ~clk;

    csa_accum i_csa_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .a     (a),
        .x     (x)
    );

    logic [63:0] model = '0;
    logic [63:0] expq[$];
    string       tag    = "R1";
    bit          mon_on = 1'b0;
    int          n_vec  = 0;
    int          n_bad  = 0;
    logic [31:0] lf     = 32'hACE1_2345;

    task automatic check(string t, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: x=%h expected %h", t, act, exp);
        end
    endtask

    // driver: apply one sample, update the plain reference, queue the expected total
    task automatic step(logic [31:0] val, logic e);
        @(negedge clk);
        a  = val;
        en = e;
        @(posedge clk);
        if (e) model = model + {{32{val[31]}}, val};
        expq.push_back(model);
    endtask

    // monitor: compare x against the queued total once the latency has passed
    always @(negedge clk) begin
        if (mon_on && expq.size() > LAT) check(tag, x, expq.pop_front());
    end

    task automatic mid_reset();
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        en    = 1'b0;
        #1 check("R7", x, 64'd0);          // clear takes effect before any edge
        repeat (2) @(posedge clk);
        #1 check("R1", x, 64'd0);
        expq.delete();
        model = '0;
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1", x, 64'd0);         // reset state
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // R5: small positive ramp checks the output latency
        tag = "R5";
        for (int i = 1; i <= 20; i++) step(32'(i), 1'b1);

        // R3: go below zero, total must show 64-bit two's complement
        tag = "R3";
        step(32'hFFFF_FFFF, 1'b1);
        for (int i = 0; i < 300; i++) step(32'hFFFF_FF00, 1'b1);

        // R4: enable low holds the total while a changes
        tag = "R4";
        for (int i = 0; i < 10; i++) step(32'h1234_5678 + 32'(i), 1'b0);

        // R2: long run of most-negative samples
        tag = "R2";
        for (int i = 0; i < 600; i++) step(32'h8000_0000, 1'b1);

        // R6: alternating extremes, then samples that change every cycle
        tag = "R6";
        for (int i = 0; i < 200; i++) step(i[0] ? 32'h8000_0000 : 32'h7FFF_FFFF, 1'b1);
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf, lf[3] | lf[7]);
        end

        // R7: reset in the middle of a run, then restart from zero
        mid_reset();
        tag = "R7";
        for (int i = 0; i < 50; i++) step(32'hFFFF_FFF0 + 32'(i), 1'b1);

        // R4: idle tail drains the queue
        tag = "R4";
        for (int i = 0; i < 4; i++) step(32'hDEAD_BEEF, 1'b0);
        @(negedge clk);
        finish_run();
    end

endmodule